// File: doc/BRIEF.md
# Physical Register Status Tracker

This block sits beside the rename stage of an out-of-order core. It keeps two flags for every physical register. The first, linked, says whether an architectural mapping still refers to the register. The second, freed, says whether the register has already been handed back to the free pool. General and special registers have separate tables. Each table is cut into the same number of banks. A register number is decoded as a bank index in its upper bits and an entry index in its lower bits, so a number is equal to bank times entries-per-bank plus entry.

The insert ports mark freshly allocated destinations as linked. The retire ports carry both the old and the new destination mapping. Depending on the restore bits, a retire releases the old mapping, or releases the new one and can re-link the old one. A scan pointer in each table steps down through the entries of all banks at once. In every bank whose pointed entry is neither linked nor freed, the block offers that register on a push port. A push port holds its offer while its ready input is low. It marks the entry freed once valid and ready are both high on the same clock edge. Insert and retire never apply back-pressure: their ready outputs are always high.

Top module: `prt_status_tracker`

## Requirements
- R1: After reset, the first GPR_INIT general entries and the first SPR_INIT special entries (counting bank 0 entries first) are linked and not freed. Every other entry is unlinked and already freed, so no push port is valid for a full pointer lap.
- R2: A register number n addresses bank n >> log2(entries-per-bank) and entry n & (entries-per-bank - 1). A pushed number is (bank << log2(entries-per-bank)) | pointer, and the push bank output equals that bank.
- R3: ins_ready and ret_ready are always 1. An insert lane with valid and its write flag set marks the named register linked and not freed. Two lanes may insert in the same cycle.
- R4: A retire lane with valid, write flag and restore = 0 clears the link of the old register, which then becomes pushable. The new register is left unchanged.
- R5: A retire lane with restore = 1 clears the link of the new register. If restore-old = 1, it also re-links the old register and clears its freed flag. Lanes apply in ascending lane order, so a higher lane wins on the same entry.
- R6: A retire lane whose valid or write flag is low changes no state.
- R7: Each scan pointer resets to 0 and moves down by one every cycle, wrapping from 0 to entries-per-bank - 1. A pending general register is offered again every 8 cycles and a pending special register every 4 cycles (default sizes).
- R8: A push candidate exists in bank b when the entry at (b, pointer) is neither linked nor freed. Candidate banks are dealt to push ports from the lowest bank upward, so port k carries the k-th lowest candidate bank. Two banks can push in one cycle.
- R9: valid and ready high on a push port marks that entry freed. It is not offered again until an insert re-links it and a retire releases it. While ready stays low the entry stays pending.
- R10: The special table has its own pointer, its own flags and its own push ports, and runs independently of the general table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | INS_PORTS | Insert lane valid |
| ins_ready | output | INS_PORTS | Insert lane ready, always 1 |
| ins_gpr_we | input | INS_PORTS | Lane allocates a general destination |
| ins_gpr_num | input | INS_PORTS x GNW | New general physical register |
| ins_spr_we | input | INS_PORTS | Lane allocates a special destination |
| ins_spr_num | input | INS_PORTS x SNW | New special physical register |
| ret_valid | input | RET_PORTS | Retire lane valid |
| ret_ready | output | RET_PORTS | Retire lane ready, always 1 |
| ret_restore | input | RET_PORTS | Lane is squashed: release the new mapping |
| ret_gpr_we | input | RET_PORTS | Lane has a general destination |
| ret_gpr_rold | input | RET_PORTS | Re-link the old general mapping on restore |
| ret_gpr_old | input | RET_PORTS x GNW | Old general physical register |
| ret_gpr_new | input | RET_PORTS x GNW | New general physical register |
| ret_spr_we | input | RET_PORTS | Lane has a special destination |
| ret_spr_rold | input | RET_PORTS | Re-link the old special mapping on restore |
| ret_spr_old | input | RET_PORTS x SNW | Old special physical register |
| ret_spr_new | input | RET_PORTS x SNW | New special physical register |
| gpr_push_valid | output | PUSH_PORTS | General register offered to the free list |
| gpr_push_ready | input | PUSH_PORTS | Free list accepts the general register |
| gpr_push_num | output | PUSH_PORTS x GNW | Offered general register number |
| gpr_push_bank | output | PUSH_PORTS x BW | Bank of the offered general register |
| spr_push_valid | output | PUSH_PORTS | Special register offered to the free list |
| spr_push_ready | input | PUSH_PORTS | Free list accepts the special register |
| spr_push_num | output | PUSH_PORTS x SNW | Offered special register number |
| spr_push_bank | output | PUSH_PORTS x BW | Bank of the offered special register |

## Verification
The hardest case to reach is two push ports firing in the same cycle. That needs releasable entries in different banks at the same entry index, at the moment the shared pointer passes that index. The bench first links registers 9 and 10 on both insert lanes together. It then retires registers 1 and 9 on both retire lanes in one cycle, so banks 0 and 1 both hold a candidate at entry 1 when the pointer reaches it. Restore with re-link is reached the same way: in one cycle, lane 0 releases register 3 and lane 1 re-links it. This shows that the lane order keeps register 3 off the push ports.

// File: rtl/prt_pkg.sv
package prt_pkg;
  // Per-register status flags.
  typedef struct packed {
    logic link;   // an architectural mapping still refers to the register
    logic freed;  // register already handed to the free pool
  } prt_entry_t;
endpackage

// File: rtl/prt_scan_ptr.sv
module prt_scan_ptr #(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (ptr == '0) begin
      ptr <= LAST;
    end else begin
      ptr <= ptr - PW'(1);
    end
  end
endmodule

// File: rtl/prt_push_pick.sv
module prt_push_pick #(
  parameter int BANKS = 2,
  parameter int PORTS = 2,
  localparam int BW = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic [BANKS-1:0]         cand,
  output logic [PORTS-1:0]         sel_valid,
  output logic [PORTS-1:0][BW-1:0] sel_bank
);
  // Port k receives the k-th lowest candidate bank.
  always_comb begin
    int unsigned seen;
    seen      = 0;
    sel_valid = '0;
    sel_bank  = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (cand[b]) begin
        for (int k = 0; k < PORTS; k++) begin
          if (seen == k) begin
            sel_valid[k] = 1'b1;
            sel_bank[k]  = BW'(b);
          end
        end
        seen = seen + 1;
      end
    end
  end
endmodule

// File: rtl/prt_table.sv
module prt_table
  import prt_pkg::*;
#(
  parameter int BANKS  = 2,
  parameter int PER    = 8,
  parameter int INIT   = 4,
  parameter int N_INS  = 2,
  parameter int N_RET  = 2,
  parameter int N_PUSH = 2,
  localparam int ENT = BANKS * PER,
  localparam int EW  = $clog2(PER),
  localparam int NW  = $clog2(ENT),
  localparam int BW  = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_INS-1:0]          ins_we,
  input  logic [N_INS-1:0][NW-1:0]  ins_num,
  input  logic [N_RET-1:0]          ret_we,
  input  logic [N_RET-1:0]          ret_restore,
  input  logic [N_RET-1:0]          ret_rold,
  input  logic [N_RET-1:0][NW-1:0]  ret_old,
  input  logic [N_RET-1:0][NW-1:0]  ret_new,
  output logic [N_PUSH-1:0]         push_valid,
  input  logic [N_PUSH-1:0]         push_ready,
  output logic [N_PUSH-1:0][NW-1:0] push_num,
  output logic [N_PUSH-1:0][BW-1:0] push_bank,
  output logic [EW-1:0]             ptr_o,
  output logic [ENT-1:0]            link_o,
  output logic [ENT-1:0]            freed_o
);
  localparam logic [NW-1:0] EMASK = NW'(PER - 1);

  prt_entry_t st_q [ENT];
  prt_entry_t st_d [ENT];
  logic [EW-1:0]    ptr;
  logic [BANKS-1:0] cand;

  // Split a register number into bank (upper bits) and entry (lower bits).
  function automatic int unsigned slot_of(input logic [NW-1:0] num);
    int unsigned bank_i;
    int unsigned ent_i;
    bank_i = int'(num >> EW);
    ent_i  = int'(num & EMASK);
    return bank_i * PER + ent_i;
  endfunction

  prt_scan_ptr #(.DEPTH(PER)) u_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .ptr  (ptr)
  );

  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      cand[b] = !st_q[b * PER + int'(ptr)].link && !st_q[b * PER + int'(ptr)].freed;
    end
  end

  prt_push_pick #(.BANKS(BANKS), .PORTS(N_PUSH)) u_pick (
    .cand     (cand),
    .sel_valid(push_valid),
    .sel_bank (push_bank)
  );

  generate
    for (genvar k = 0; k < N_PUSH; k++) begin : g_num
      assign push_num[k] = NW'((NW'(push_bank[k]) << EW) | NW'(ptr));
    end
  endgenerate

  // Order inside a cycle: inserts, then retire lanes in ascending order, then frees.
  always_comb begin
    for (int i = 0; i < ENT; i++) st_d[i] = st_q[i];
    for (int i = 0; i < N_INS; i++) begin
      if (ins_we[i]) begin
        st_d[slot_of(ins_num[i])].link  = 1'b1;
        st_d[slot_of(ins_num[i])].freed = 1'b0;
      end
    end
    for (int r = 0; r < N_RET; r++) begin
      if (ret_we[r]) begin
        if (!ret_restore[r]) begin
          st_d[slot_of(ret_old[r])].link = 1'b0;
        end else begin
          st_d[slot_of(ret_new[r])].link = 1'b0;
          if (ret_rold[r]) begin
            st_d[slot_of(ret_old[r])].link  = 1'b1;
            st_d[slot_of(ret_old[r])].freed = 1'b0;
          end
        end
      end
    end
    for (int k = 0; k < N_PUSH; k++) begin
      if (push_valid[k] && push_ready[k]) begin
        st_d[int'(push_bank[k]) * PER + int'(ptr)].freed = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENT; i++) begin
        st_q[i].link  <= (i < INIT);
        st_q[i].freed <= !(i < INIT);
      end
    end else begin
      for (int i = 0; i < ENT; i++) st_q[i] <= st_d[i];
    end
  end

  assign ptr_o = ptr;
  always_comb begin
    for (int i = 0; i < ENT; i++) begin
      link_o[i]  = st_q[i].link;
      freed_o[i] = st_q[i].freed;
    end
  end
endmodule

// File: rtl/prt_status_tracker.sv
module prt_status_tracker #(
  parameter int NUM_BANKS    = 2,
  parameter int GPR_PER_BANK = 8,
  parameter int SPR_PER_BANK = 4,
  parameter int GPR_INIT     = 4,
  parameter int SPR_INIT     = 2,
  parameter int INS_PORTS    = 2,
  parameter int RET_PORTS    = 2,
  parameter int PUSH_PORTS   = 2,
  localparam int GNW = $clog2(NUM_BANKS * GPR_PER_BANK),
  localparam int SNW = $clog2(NUM_BANKS * SPR_PER_BANK),
  localparam int BW  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [INS_PORTS-1:0]           ins_valid,
  output logic [INS_PORTS-1:0]           ins_ready,
  input  logic [INS_PORTS-1:0]           ins_gpr_we,
  input  logic [INS_PORTS-1:0][GNW-1:0]  ins_gpr_num,
  input  logic [INS_PORTS-1:0]           ins_spr_we,
  input  logic [INS_PORTS-1:0][SNW-1:0]  ins_spr_num,
  input  logic [RET_PORTS-1:0]           ret_valid,
  output logic [RET_PORTS-1:0]           ret_ready,
  input  logic [RET_PORTS-1:0]           ret_restore,
  input  logic [RET_PORTS-1:0]           ret_gpr_we,
  input  logic [RET_PORTS-1:0]           ret_gpr_rold,
  input  logic [RET_PORTS-1:0][GNW-1:0]  ret_gpr_old,
  input  logic [RET_PORTS-1:0][GNW-1:0]  ret_gpr_new,
  input  logic [RET_PORTS-1:0]           ret_spr_we,
  input  logic [RET_PORTS-1:0]           ret_spr_rold,
  input  logic [RET_PORTS-1:0][SNW-1:0]  ret_spr_old,
  input  logic [RET_PORTS-1:0][SNW-1:0]  ret_spr_new,
  output logic [PUSH_PORTS-1:0]          gpr_push_valid,
  input  logic [PUSH_PORTS-1:0]          gpr_push_ready,
  output logic [PUSH_PORTS-1:0][GNW-1:0] gpr_push_num,
  output logic [PUSH_PORTS-1:0][BW-1:0]  gpr_push_bank,
  output logic [PUSH_PORTS-1:0]          spr_push_valid,
  input  logic [PUSH_PORTS-1:0]          spr_push_ready,
  output logic [PUSH_PORTS-1:0][SNW-1:0] spr_push_num,
  output logic [PUSH_PORTS-1:0][BW-1:0]  spr_push_bank
);
  localparam int GEW  = $clog2(GPR_PER_BANK);
  localparam int SEW  = $clog2(SPR_PER_BANK);
  localparam int GENT = NUM_BANKS * GPR_PER_BANK;
  localparam int SENT = NUM_BANKS * SPR_PER_BANK;

  logic [GEW-1:0]  gpr_ptr;
  logic [SEW-1:0]  spr_ptr;
  logic [GENT-1:0] gpr_link, gpr_freed;
  logic [SENT-1:0] spr_link, spr_freed;

  assign ins_ready = '1;
  assign ret_ready = '1;

  prt_table #(
    .BANKS(NUM_BANKS), .PER(GPR_PER_BANK), .INIT(GPR_INIT),
    .N_INS(INS_PORTS), .N_RET(RET_PORTS), .N_PUSH(PUSH_PORTS)
  ) u_gpr (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_we     (ins_valid & ins_gpr_we),
    .ins_num    (ins_gpr_num),
    .ret_we     (ret_valid & ret_gpr_we),
    .ret_restore(ret_restore),
    .ret_rold   (ret_gpr_rold),
    .ret_old    (ret_gpr_old),
    .ret_new    (ret_gpr_new),
    .push_valid (gpr_push_valid),
    .push_ready (gpr_push_ready),
    .push_num   (gpr_push_num),
    .push_bank  (gpr_push_bank),
    .ptr_o      (gpr_ptr),
    .link_o     (gpr_link),
    .freed_o    (gpr_freed)
  );

  prt_table #(
    .BANKS(NUM_BANKS), .PER(SPR_PER_BANK), .INIT(SPR_INIT),
    .N_INS(INS_PORTS), .N_RET(RET_PORTS), .N_PUSH(PUSH_PORTS)
  ) u_spr (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_we     (ins_valid & ins_spr_we),
    .ins_num    (ins_spr_num),
    .ret_we     (ret_valid & ret_spr_we),
    .ret_restore(ret_restore),
    .ret_rold   (ret_spr_rold),
    .ret_old    (ret_spr_old),
    .ret_new    (ret_spr_new),
    .push_valid (spr_push_valid),
    .push_ready (spr_push_ready),
    .push_num   (spr_push_num),
    .push_bank  (spr_push_bank),
    .ptr_o      (spr_ptr),
    .link_o     (spr_link),
    .freed_o    (spr_freed)
  );
endmodule

// File: rtl/prt_status_tracker_chk.sv
module prt_status_tracker_chk #(
  parameter int NUM_BANKS    = 2,
  parameter int GPR_PER_BANK = 8,
  parameter int SPR_PER_BANK = 4,
  parameter int INS_PORTS    = 2,
  parameter int RET_PORTS    = 2,
  parameter int PUSH_PORTS   = 2,
  localparam int GNW  = $clog2(NUM_BANKS * GPR_PER_BANK),
  localparam int GEW  = $clog2(GPR_PER_BANK),
  localparam int SEW  = $clog2(SPR_PER_BANK),
  localparam int GENT = NUM_BANKS * GPR_PER_BANK,
  localparam int BW   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [GEW-1:0]                 gpr_ptr,
  input logic [SEW-1:0]                 spr_ptr,
  input logic [GENT-1:0]                gpr_link,
  input logic [GENT-1:0]                gpr_freed,
  input logic [INS_PORTS-1:0]           ins_valid,
  input logic [INS_PORTS-1:0]           ins_gpr_we,
  input logic [INS_PORTS-1:0][GNW-1:0]  ins_gpr_num,
  input logic [RET_PORTS-1:0]           ret_valid,
  input logic [RET_PORTS-1:0]           ret_restore,
  input logic [RET_PORTS-1:0]           ret_gpr_we,
  input logic [RET_PORTS-1:0][GNW-1:0]  ret_gpr_old,
  input logic [PUSH_PORTS-1:0]          gpr_push_valid,
  input logic [PUSH_PORTS-1:0]          gpr_push_ready,
  input logic [PUSH_PORTS-1:0][GNW-1:0] gpr_push_num,
  input logic [PUSH_PORTS-1:0][BW-1:0]  gpr_push_bank
);
  localparam logic [GEW-1:0] GLAST = GEW'(GPR_PER_BANK - 1);
  localparam logic [SEW-1:0] SLAST = SEW'(SPR_PER_BANK - 1);

  // R7: pointers step down and wrap
  a_r7_gpr_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> gpr_ptr == (($past(gpr_ptr) == '0) ? GLAST : $past(gpr_ptr) - GEW'(1)));
  a_r7_spr_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> spr_ptr == (($past(spr_ptr) == '0) ? SLAST : $past(spr_ptr) - SEW'(1)));

  // R4: lone retire lane 0 without restore unlinks the old register
  a_r4_old_unlinked: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid == RET_PORTS'(1) && ret_gpr_we[0] && !ret_restore[0] && ins_valid == '0)
    |=> !gpr_link[$past(ret_gpr_old[0])]);

  generate
    for (genvar k = 0; k < INS_PORTS; k++) begin : g_ins
      // R3: accepted insert links its register
      a_r3_insert_links: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid[k] && ins_gpr_we[k] && ret_valid == '0)
        |=> (gpr_link[$past(ins_gpr_num[k])] && !gpr_freed[$past(ins_gpr_num[k])]));
    end
    for (genvar k = 0; k < PUSH_PORTS; k++) begin : g_push
      // R9: handshake marks the entry freed
      a_r9_handshake_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (gpr_push_valid[k] && gpr_push_ready[k]) |=> gpr_freed[$past(gpr_push_num[k])]);
      for (genvar j = k + 1; j < PUSH_PORTS; j++) begin : g_pair
        // R8: two ports never offer the same bank
        a_r8_distinct_banks: assert property (@(posedge clk) disable iff (!rst_n)
          !(gpr_push_valid[k] && gpr_push_valid[j] && gpr_push_bank[k] == gpr_push_bank[j]));
      end
    end
  endgenerate
endmodule

bind prt_status_tracker prt_status_tracker_chk #(
  .NUM_BANKS(NUM_BANKS), .GPR_PER_BANK(GPR_PER_BANK), .SPR_PER_BANK(SPR_PER_BANK),
  .INS_PORTS(INS_PORTS), .RET_PORTS(RET_PORTS), .PUSH_PORTS(PUSH_PORTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gpr_ptr(gpr_ptr), .spr_ptr(spr_ptr),
  .gpr_link(gpr_link), .gpr_freed(gpr_freed),
  .ins_valid(ins_valid), .ins_gpr_we(ins_gpr_we), .ins_gpr_num(ins_gpr_num),
  .ret_valid(ret_valid), .ret_restore(ret_restore), .ret_gpr_we(ret_gpr_we),
  .ret_gpr_old(ret_gpr_old), .gpr_push_valid(gpr_push_valid),
  .gpr_push_ready(gpr_push_ready), .gpr_push_num(gpr_push_num),
  .gpr_push_bank(gpr_push_bank)
);

// File: tb/prt_status_tracker_tb.sv
module prt_status_tracker_tb;
  localparam int GNW = 4;
  localparam int SNW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]          ins_valid, ins_ready, ins_gpr_we, ins_spr_we;
  logic [1:0][GNW-1:0] ins_gpr_num;
  logic [1:0][SNW-1:0] ins_spr_num;
  logic [1:0]          ret_valid, ret_ready, ret_restore, ret_gpr_we, ret_gpr_rold;
  logic [1:0]          ret_spr_we, ret_spr_rold;
  logic [1:0][GNW-1:0] ret_gpr_old, ret_gpr_new;
  logic [1:0][SNW-1:0] ret_spr_old, ret_spr_new;
  logic [1:0]          gpr_push_valid, gpr_push_ready, spr_push_valid, spr_push_ready;
  logic [1:0][GNW-1:0] gpr_push_num;
  logic [1:0][SNW-1:0] spr_push_num;
  logic [1:0][0:0]     gpr_push_bank, spr_push_bank;

  prt_status_tracker u_dut (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_gpr_we(ins_gpr_we),
    .ins_gpr_num(ins_gpr_num), .ins_spr_we(ins_spr_we), .ins_spr_num(ins_spr_num),
    .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_restore(ret_restore),
    .ret_gpr_we(ret_gpr_we), .ret_gpr_rold(ret_gpr_rold), .ret_gpr_old(ret_gpr_old),
    .ret_gpr_new(ret_gpr_new), .ret_spr_we(ret_spr_we), .ret_spr_rold(ret_spr_rold),
    .ret_spr_old(ret_spr_old), .ret_spr_new(ret_spr_new),
    .gpr_push_valid(gpr_push_valid), .gpr_push_ready(gpr_push_ready),
    .gpr_push_num(gpr_push_num), .gpr_push_bank(gpr_push_bank),
    .spr_push_valid(spr_push_valid), .spr_push_ready(spr_push_ready),
    .spr_push_num(spr_push_num), .spr_push_bank(spr_push_bank)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  bit pushed_g [16];

  typedef struct packed {
    logic [3:0] ins;
    logic [3:0] old;
    logic [3:0] nw;
    logic       rs;
    logic       ro;
    logic [3:0] enum_num;
    logic       ebank;
  } row_t;

  // insert ins; retire (old,new,restore,restore_old); expect push of enum_num in ebank on port 0
  localparam row_t ROWS [5] = '{
    '{4'd5,  4'd2,  4'd5,  1'b0, 1'b0, 4'd2,  1'b0},  // R4 old released
    '{4'd13, 4'd13, 4'd5,  1'b0, 1'b0, 4'd13, 1'b1},  // R2/R8 lone bank 1 goes to port 0
    '{4'd15, 4'd0,  4'd15, 1'b1, 1'b0, 4'd15, 1'b1},  // R5 new released, old kept
    '{4'd6,  4'd6,  4'd0,  1'b0, 1'b0, 4'd6,  1'b0},  // R4 bank 0 upper entry
    '{4'd2,  4'd2,  4'd5,  1'b0, 1'b0, 4'd2,  1'b0}   // R9 re-linked register pushed again
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ins_valid = '0; ins_gpr_we = '0; ins_spr_we = '0; ins_gpr_num = '0; ins_spr_num = '0;
    ret_valid = '0; ret_restore = '0; ret_gpr_we = '0; ret_gpr_rold = '0;
    ret_spr_we = '0; ret_spr_rold = '0; ret_gpr_old = '0; ret_gpr_new = '0;
    ret_spr_old = '0; ret_spr_new = '0;
  endtask

  task automatic insert_g(input int lane, input int num);
    ins_valid[lane] = 1'b1; ins_gpr_we[lane] = 1'b1; ins_gpr_num[lane] = GNW'(num);
    pushed_g[num] = 1'b0;
  endtask

  task automatic retire_g(input int lane, input bit v, input bit we, input int old,
                          input int nw, input bit rs, input bit ro);
    ret_valid[lane] = v; ret_gpr_we[lane] = we; ret_gpr_old[lane] = GNW'(old);
    ret_gpr_new[lane] = GNW'(nw); ret_restore[lane] = rs; ret_gpr_rold[lane] = ro;
  endtask

  task automatic commit();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic wait_g(output bit found, output int num, output int port, output int bank);
    found = 0; num = 0; port = 0; bank = 0;
    for (int c = 0; c < 12 && !found; c++) begin
      for (int k = 1; k >= 0; k--) begin
        if (gpr_push_valid[k]) begin
          found = 1; num = int'(gpr_push_num[k]); port = k; bank = int'(gpr_push_bank[k]);
        end
      end
      if (!found) @(negedge clk);
    end
  endtask

  task automatic ack_g(input int port);
    gpr_push_ready[port] = 1'b1;
    @(negedge clk);
    gpr_push_ready = '0;
  endtask

  task automatic quiet(input int n, output int hits);
    hits = 0;
    for (int c = 0; c < n; c++) begin
      if (gpr_push_valid != '0 || spr_push_valid != '0) hits++;
      @(negedge clk);
    end
  endtask

  // R9 monitor: a general register is never accepted twice without a re-link
  always @(posedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 2; k++) begin
        if (gpr_push_valid[k] && gpr_push_ready[k]) begin
          chk(!pushed_g[gpr_push_num[k]], "R9 double push", int'(gpr_push_num[k]), -1);
          pushed_g[gpr_push_num[k]] = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit found;
    int num, port, bank, hits, lap;
    idle_inputs();
    gpr_push_ready = '0; spr_push_ready = '0;
    for (int i = 0; i < 16; i++) pushed_g[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset image offers nothing over two laps
    quiet(16, hits);
    chk(hits == 0, "R1 reset quiet", hits, 0);
    // R3: readies always high
    chk(ins_ready == 2'b11 && ret_ready == 2'b11, "R3 ready tied", int'({ins_ready, ret_ready}), 15);

    // Vector table
    foreach (ROWS[r]) begin
      insert_g(0, int'(ROWS[r].ins)); commit();
      retire_g(0, 1, 1, int'(ROWS[r].old), int'(ROWS[r].nw), ROWS[r].rs, ROWS[r].ro); commit();
      wait_g(found, num, port, bank);
      chk(found, "R4/R5 release produces push", int'(found), 1);
      chk(num == int'(ROWS[r].enum_num), "R2 pushed number", num, int'(ROWS[r].enum_num));
      chk(port == 0 && bank == int'(ROWS[r].ebank), "R8 port0 bank", bank, int'(ROWS[r].ebank));
      ack_g(port);
      quiet(16, hits);
      chk(hits == 0, "R9 freed entry silent", hits, 0);
    end

    // R7 + R9: back-pressure holds the entry; it comes back one lap later
    insert_g(0, 7); commit();
    retire_g(0, 1, 1, 7, 5, 0, 0); commit();
    wait_g(found, num, port, bank);
    chk(found && num == 7, "R9 pending offer", num, 7);
    lap = 0;
    for (int c = 1; c <= 12 && lap == 0; c++) begin
      @(negedge clk);
      if (gpr_push_valid[0] && gpr_push_num[0] == 4'd7) lap = c;
    end
    chk(lap == 8, "R7 general lap", lap, 8);
    ack_g(0);

    // R8: both banks release at entry 1 in the same cycle; R3 two insert lanes
    insert_g(0, 9); insert_g(1, 10); commit();
    retire_g(0, 1, 1, 1, 10, 0, 0); retire_g(1, 1, 1, 9, 12, 0, 0); commit();
    wait_g(found, num, port, bank);
    chk(gpr_push_valid == 2'b11, "R8 two ports together", int'(gpr_push_valid), 3);
    chk(gpr_push_num[0] == 4'd1 && gpr_push_bank[0] == 1'b0, "R8 port0 bank0", int'(gpr_push_num[0]), 1);
    chk(gpr_push_num[1] == 4'd9 && gpr_push_bank[1] == 1'b1, "R8 port1 bank1", int'(gpr_push_num[1]), 9);
    gpr_push_ready = 2'b11; @(negedge clk); gpr_push_ready = '0;

    // R6: retire with valid low or write flag low leaves register 0 linked
    retire_g(0, 0, 1, 0, 5, 0, 0); commit();
    retire_g(0, 1, 0, 0, 5, 0, 0); commit();
    quiet(16, hits);
    chk(hits == 0, "R6 ignored retire", hits, 0);

    // R5: lane 0 releases 3, lane 1 restores with re-link; lane 1 wins, 14 is released
    insert_g(0, 14); commit();
    retire_g(0, 1, 1, 3, 5, 0, 0); retire_g(1, 1, 1, 3, 14, 1, 1); commit();
    wait_g(found, num, port, bank);
    chk(found && num == 14, "R5 restore releases new", num, 14);
    ack_g(port);
    quiet(16, hits);
    chk(hits == 0, "R5 re-linked old never offered", hits, 0);

    // R10 + R7: special table, independent lap of 4
    ins_valid[0] = 1'b1; ins_spr_we[0] = 1'b1; ins_spr_num[0] = 3'd5; commit();
    ret_valid[0] = 1'b1; ret_spr_we[0] = 1'b1; ret_spr_old[0] = 3'd0; ret_spr_new[0] = 3'd5; commit();
    found = 0;
    for (int c = 0; c < 8 && !found; c++) begin
      if (spr_push_valid[0]) found = 1; else @(negedge clk);
    end
    chk(found && spr_push_num[0] == 3'd0 && spr_push_bank[0] == 1'b0, "R10 special push",
        int'(spr_push_num[0]), 0);
    chk(gpr_push_valid == '0, "R10 general table untouched", int'(gpr_push_valid), 0);
    lap = 0;
    for (int c = 1; c <= 8 && lap == 0; c++) begin
      @(negedge clk);
      if (spr_push_valid[0]) lap = c;
    end
    chk(lap == 4, "R7 special lap", lap, 4);
    spr_push_ready[0] = 1'b1; @(negedge clk); spr_push_ready = '0;
    quiet(8, hits);
    chk(hits == 0, "R9 special freed silent", hits, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule